// File: doc/BRIEF.md
# Processor Core Power-State Controller

This block follows the low-power state of a single processor core. Each cycle it looks at one-cycle request strobes from the execution side. These are a halt instruction, a monitor-wait request that carries a target depth, and a power-level register read for depth 2 or depth 3. Any of them can take a running core into one of four idle states: a halt-entered depth-1 state, a monitor-wait depth-1 state, depth 2 and depth 3. Each idle state has its own wake rule. The halt state wakes on any break source. The other three also wake on a monitor event, but only while the clock-stop line is low.

A level-sensitive clock-stop request parks the core in a stop-grant state. This happens from run or from either depth-1 state, and the block records which of those three states the core came from. When the request drops, the core goes back to exactly that state. In depth 2 and depth 3 the request does nothing.

While halted, the core can service a bus snoop. It spends one cycle in a snoop sub-state and then goes back to halt without waking. A core reset line puts the core in run from any state.

The block drives the state code, a core-clock enable, a snoop-service flag and a wake pulse. All outputs are registered and change on the same edge as the state.

Top module: `core_pstate_ctrl`

## Requirements
- R1: When `rst_i` or `core_rst_i` is high at a clock edge, the state after that edge is run (code 0), `clk_en_o` is 1, and `wake_o` and `snoop_svc_o` are 0. This holds from every state, including stop-grant and the snoop sub-state.
- R2: In run with `clkstop_i` low, one request strobe moves the core on the next edge as follows. `halt_i` goes to halt (code 1). `mwait_i` with `mwait_depth_i` of 0 or 1 goes to monitor-wait depth 1 (code 2). `plvl2_rd_i`, or `mwait_i` with depth 2, goes to depth 2 (code 3). `plvl3_rd_i`, or `mwait_i` with depth 3, goes to depth 3 (code 4).
- R3: When several requests arrive together in run, the winner is chosen in this order, highest first: clock-stop, depth 3, depth 2, monitor-wait depth 1, halt.
- R4: In halt, the core returns to run on the next edge if any bit of `brk_src_i` is high. The bits are 0 A20-mask transition, 1 INIT, 2 INTR, 3 NMI, 4 probe request, 5 SMI and 6 APIC interrupt. A monitor event alone leaves the core in halt.
- R5: In monitor-wait depth 1, depth 2 and depth 3, the core returns to run on the next edge only if a break bit or `mon_event_i` is high while `clkstop_i` is low.
- R6: If `clkstop_i` is high in run, halt or monitor-wait depth 1, the core moves to stop-grant (code 5). It stays there while `clkstop_i` is high. On the edge after `clkstop_i` goes low, it returns to the state it came from.
- R7: In depth 2 and depth 3, `clkstop_i` has no effect, whether it is rising, high or falling. In stop-grant, break sources, the monitor event and snoops have no effect.
- R8: A `snoop_i` strobe in halt moves the core to the snoop sub-state (code 6) for exactly one cycle, with `snoop_svc_o` high. The core then returns to halt. Snoops in any other state are ignored.
- R9: `clk_en_o` is high exactly when the state is run.
- R10: `wake_o` is high for exactly one cycle at each entry into run from another state. It stays low when the entry is caused by a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high block reset |
| core_rst_i | input | 1 | Core reset line; forces run with no wake pulse |
| halt_i | input | 1 | Halt instruction strobe |
| mwait_i | input | 1 | Monitor-wait request strobe |
| mwait_depth_i | input | DEPTH_W | Monitor-wait target depth (0/1, 2, 3) |
| plvl2_rd_i | input | 1 | Depth-2 power-level read strobe |
| plvl3_rd_i | input | 1 | Depth-3 power-level read strobe |
| clkstop_i | input | 1 | Clock-stop request level |
| snoop_i | input | 1 | Bus snoop strobe |
| mon_event_i | input | 1 | Monitor event |
| brk_src_i | input | NUM_BRK | Break sources (bit map in R4) |
| state_o | output | 3 | Current state code |
| clk_en_o | output | 1 | Core clock enable |
| snoop_svc_o | output | 1 | Snoop being serviced this cycle |
| wake_o | output | 1 | One-cycle pulse on entry into run |

## Verification
The bench checks that a clock-stop released from halt goes back to halt and one released from monitor-wait goes back to monitor-wait. A design that keeps no record of the origin would send both to run and raise a false wake pulse. It also asserts clock-stop together with a break while the core sits in depth 2. A design that treats the request as a stop-grant entry, or ignores the gating of the break by clock-stop, would leave depth 2 in the wrong direction.

Other checks cover several more cases. A monitor event alone must not wake a halted core. A snoop must not be taken in depth 3 or in stop-grant. Each of the seven break bits is checked separately. A core reset from stop-grant or from the snoop sub-state must come back to run with no wake pulse. Any of these mistakes shows up as a wrong state code or a wrong pulse on the next sampled cycle.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN   = 3'd0,
    PS_HALT  = 3'd1,
    PS_MWAIT = 3'd2,
    PS_DEEP2 = 3'd3,
    PS_DEEP3 = 3'd4,
    PS_STOPG = 3'd5,
    PS_SNOOP = 3'd6
  } pstate_e;
endpackage

// File: rtl/pstate_wake_sources.sv
module pstate_wake_sources #(
  parameter int unsigned NUM_BRK = 7
) (
  input  logic [NUM_BRK-1:0] brk_src_i,
  input  logic               mon_event_i,
  input  logic               clkstop_i,
  output logic               halt_brk_o,
  output logic               core_brk_o
);
  logic [NUM_BRK:0] or_chain;

  assign or_chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_BRK; g++) begin : g_or
    assign or_chain[g+1] = or_chain[g] | brk_src_i[g];
  end

  assign halt_brk_o = or_chain[NUM_BRK];
  // Deeper states wake on break or monitor event, gated by clock-stop low.
  assign core_brk_o = (or_chain[NUM_BRK] | mon_event_i) & ~clkstop_i;
endmodule

// File: rtl/pstate_entry_sel.sv
module pstate_entry_sel
  import pstate_pkg::*;
#(
  parameter int unsigned DEPTH_W = 2
) (
  input  logic               clkstop_i,
  input  logic               halt_i,
  input  logic               mwait_i,
  input  logic [DEPTH_W-1:0] mwait_depth_i,
  input  logic               plvl2_rd_i,
  input  logic               plvl3_rd_i,
  output logic               valid_o,
  output pstate_e            target_o
);
  localparam logic [DEPTH_W-1:0] D2 = DEPTH_W'(2);
  localparam logic [DEPTH_W-1:0] D3 = DEPTH_W'(3);

  logic want_d3, want_d2, want_m1;

  assign want_d3 = plvl3_rd_i | (mwait_i & (mwait_depth_i == D3));
  assign want_d2 = plvl2_rd_i | (mwait_i & (mwait_depth_i == D2));
  assign want_m1 = mwait_i & (mwait_depth_i != D2) & (mwait_depth_i != D3);

  // Fixed priority: clock-stop, depth 3, depth 2, monitor-wait 1, halt.
  always_comb begin
    valid_o  = 1'b1;
    target_o = PS_RUN;
    if (clkstop_i)    target_o = PS_STOPG;
    else if (want_d3) target_o = PS_DEEP3;
    else if (want_d2) target_o = PS_DEEP2;
    else if (want_m1) target_o = PS_MWAIT;
    else if (halt_i)  target_o = PS_HALT;
    else              valid_o  = 1'b0;
  end
endmodule

// File: rtl/pstate_fsm.sv
module pstate_fsm
  import pstate_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  logic    core_rst_i,
  input  logic    clkstop_i,
  input  logic    snoop_i,
  input  logic    halt_brk_i,
  input  logic    core_brk_i,
  input  logic    entry_valid_i,
  input  pstate_e entry_target_i,
  output pstate_e state_o,
  output pstate_e nxt_o
);
  pstate_e state_q, nxt;
  pstate_e origin_q, origin_d;

  always_comb begin
    nxt      = state_q;
    origin_d = origin_q;
    unique case (state_q)
      PS_RUN: begin
        if (entry_valid_i) begin
          nxt = entry_target_i;
          if (entry_target_i == PS_STOPG) origin_d = PS_RUN;
        end
      end
      PS_HALT: begin
        if (clkstop_i) begin
          nxt      = PS_STOPG;
          origin_d = PS_HALT;
        end else if (halt_brk_i) begin
          nxt = PS_RUN;
        end else if (snoop_i) begin
          nxt = PS_SNOOP;
        end
      end
      PS_MWAIT: begin
        if (clkstop_i) begin
          nxt      = PS_STOPG;
          origin_d = PS_MWAIT;
        end else if (core_brk_i) begin
          nxt = PS_RUN;
        end
      end
      PS_DEEP2, PS_DEEP3: begin
        if (core_brk_i) nxt = PS_RUN;
      end
      PS_STOPG: begin
        if (!clkstop_i) nxt = origin_q;
      end
      PS_SNOOP: nxt = PS_HALT;
      default:  nxt = PS_RUN;
    endcase
    if (core_rst_i) nxt = PS_RUN;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= PS_RUN;
      origin_q <= PS_RUN;
    end else begin
      state_q  <= nxt;
      origin_q <= origin_d;
    end
  end

  assign state_o = state_q;
  assign nxt_o   = nxt;

  p_core_reset_run_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    core_rst_i |=> state_q == PS_RUN);

  p_halt_entry_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == PS_RUN && entry_valid_i && entry_target_i == PS_HALT && !core_rst_i)
    |=> state_q == PS_HALT);

  p_stopg_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == PS_STOPG && clkstop_i && !core_rst_i) |=> state_q == PS_STOPG);

  p_deep_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    ((state_q == PS_DEEP2 || state_q == PS_DEEP3) && !core_brk_i && !core_rst_i)
    |=> $stable(state_q));

  p_snoop_return_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == PS_SNOOP && !core_rst_i) |=> state_q == PS_HALT);
endmodule

// File: rtl/pstate_outputs.sv
module pstate_outputs
  import pstate_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_i,
  input  logic    core_rst_i,
  input  pstate_e cur_i,
  input  pstate_e nxt_i,
  output logic    clk_en_o,
  output logic    snoop_svc_o,
  output logic    wake_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      clk_en_o    <= 1'b1;
      snoop_svc_o <= 1'b0;
      wake_o      <= 1'b0;
    end else begin
      clk_en_o    <= (nxt_i == PS_RUN);
      snoop_svc_o <= (nxt_i == PS_SNOOP);
      wake_o      <= (nxt_i == PS_RUN) && (cur_i != PS_RUN) && !core_rst_i;
    end
  end

  p_clk_en_run_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    clk_en_o == (cur_i == PS_RUN));

  p_snoop_flag_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    snoop_svc_o == (cur_i == PS_SNOOP));

  p_wake_entry_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_o |-> (cur_i == PS_RUN && $past(cur_i) != PS_RUN));

  p_wake_single_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_o |=> !wake_o);

  p_no_wake_on_reset_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    core_rst_i |=> !wake_o);
endmodule

// File: rtl/core_pstate_ctrl.sv
module core_pstate_ctrl
  import pstate_pkg::*;
#(
  parameter int unsigned DEPTH_W = 2,
  parameter int unsigned NUM_BRK = 7
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               core_rst_i,
  input  logic               halt_i,
  input  logic               mwait_i,
  input  logic [DEPTH_W-1:0] mwait_depth_i,
  input  logic               plvl2_rd_i,
  input  logic               plvl3_rd_i,
  input  logic               clkstop_i,
  input  logic               snoop_i,
  input  logic               mon_event_i,
  input  logic [NUM_BRK-1:0] brk_src_i,
  output logic [2:0]         state_o,
  output logic               clk_en_o,
  output logic               snoop_svc_o,
  output logic               wake_o
);
  logic    halt_brk, core_brk, entry_valid;
  pstate_e entry_target, cur_state, nxt_state;

  pstate_wake_sources #(.NUM_BRK(NUM_BRK)) u_wake (
    .brk_src_i  (brk_src_i),
    .mon_event_i(mon_event_i),
    .clkstop_i  (clkstop_i),
    .halt_brk_o (halt_brk),
    .core_brk_o (core_brk)
  );

  pstate_entry_sel #(.DEPTH_W(DEPTH_W)) u_entry (
    .clkstop_i    (clkstop_i),
    .halt_i       (halt_i),
    .mwait_i      (mwait_i),
    .mwait_depth_i(mwait_depth_i),
    .plvl2_rd_i   (plvl2_rd_i),
    .plvl3_rd_i   (plvl3_rd_i),
    .valid_o      (entry_valid),
    .target_o     (entry_target)
  );

  pstate_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .core_rst_i    (core_rst_i),
    .clkstop_i     (clkstop_i),
    .snoop_i       (snoop_i),
    .halt_brk_i    (halt_brk),
    .core_brk_i    (core_brk),
    .entry_valid_i (entry_valid),
    .entry_target_i(entry_target),
    .state_o       (cur_state),
    .nxt_o         (nxt_state)
  );

  pstate_outputs u_out (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .core_rst_i (core_rst_i),
    .cur_i      (cur_state),
    .nxt_i      (nxt_state),
    .clk_en_o   (clk_en_o),
    .snoop_svc_o(snoop_svc_o),
    .wake_o     (wake_o)
  );

  assign state_o = cur_state;
endmodule

// File: tb/tb_core_pstate_ctrl.sv
module tb_core_pstate_ctrl;
  localparam int DEPTH_W = 2;
  localparam int NUM_BRK = 7;
  localparam logic [2:0] S_RUN = 3'd0, S_HALT = 3'd1, S_MW = 3'd2, S_D2 = 3'd3,
                         S_D3 = 3'd4, S_SG = 3'd5, S_SN = 3'd6;

  logic clk = 1'b0;
  logic rst, core_rst, halt, mwait, plvl2, plvl3, clkstop, snoop, mon;
  logic [DEPTH_W-1:0] mdepth;
  logic [NUM_BRK-1:0] brk;
  logic [2:0] state;
  logic clk_en, snoop_svc, wake;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  core_pstate_ctrl #(.DEPTH_W(DEPTH_W), .NUM_BRK(NUM_BRK)) dut (
    .clk_i(clk), .rst_i(rst), .core_rst_i(core_rst), .halt_i(halt), .mwait_i(mwait),
    .mwait_depth_i(mdepth), .plvl2_rd_i(plvl2), .plvl3_rd_i(plvl3), .clkstop_i(clkstop),
    .snoop_i(snoop), .mon_event_i(mon), .brk_src_i(brk), .state_o(state),
    .clk_en_o(clk_en), .snoop_svc_o(snoop_svc), .wake_o(wake)
  );

  task automatic clear_strobes();
    core_rst = 0; halt = 0; mwait = 0; mdepth = '0; plvl2 = 0; plvl3 = 0;
    snoop = 0; mon = 0; brk = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    clear_strobes();
  endtask

  task automatic chk(string tag, logic [2:0] es, logic ec, logic ew, logic esn);
    checks++;
    if (state !== es || clk_en !== ec || wake !== ew || snoop_svc !== esn) begin
      failures++;
      $display("FAIL %s: state=%0d clk_en=%0b wake=%0b snoop=%0b expected state=%0d clk_en=%0b wake=%0b snoop=%0b",
               tag, state, clk_en, wake, snoop_svc, es, ec, ew, esn);
    end
  endtask

  task automatic do_reset();
    rst = 1; clkstop = 0; clear_strobes();
    repeat (2) @(posedge clk); #1;
    rst = 0;
  endtask

  task automatic break_to_run(string tag);
    brk[2] = 1; tick();
    chk(tag, S_RUN, 1, 1, 0);
    tick();
    chk(tag, S_RUN, 1, 0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset state", S_RUN, 1, 0, 0);
    snoop = 1; tick();
    chk("R8 snoop in run ignored", S_RUN, 1, 0, 0);
  endtask

  task automatic t_entries();
    halt = 1; tick(); chk("R2 halt entry", S_HALT, 0, 0, 0);
    break_to_run("R10 wake from halt");
    mwait = 1; mdepth = 2'd1; tick(); chk("R2 mwait depth1", S_MW, 0, 0, 0);
    mon = 1; tick(); chk("R5 monitor event wakes mwait", S_RUN, 1, 1, 0);
    mwait = 1; mdepth = 2'd0; tick(); chk("R2 mwait depth0", S_MW, 0, 0, 0);
    break_to_run("R5 break wakes mwait");
    plvl2 = 1; tick(); chk("R2 plvl2 read", S_D2, 0, 0, 0);
    break_to_run("R5 break wakes depth2");
    mwait = 1; mdepth = 2'd2; tick(); chk("R2 mwait depth2", S_D2, 0, 0, 0);
    mon = 1; tick(); chk("R5 monitor wakes depth2", S_RUN, 1, 1, 0);
    plvl3 = 1; tick(); chk("R2 plvl3 read", S_D3, 0, 0, 0);
    break_to_run("R5 break wakes depth3");
    mwait = 1; mdepth = 2'd3; tick(); chk("R2 mwait depth3", S_D3, 0, 0, 0);
    break_to_run("R10 wake from depth3");
  endtask

  task automatic t_priority();
    clkstop = 1; halt = 1; mwait = 1; mdepth = 2'd1; plvl2 = 1; plvl3 = 1; tick();
    chk("R3 clock-stop wins", S_SG, 0, 0, 0);
    clkstop = 0; tick(); chk("R6 release to run", S_RUN, 1, 1, 0);
    halt = 1; mwait = 1; mdepth = 2'd1; plvl2 = 1; plvl3 = 1; tick();
    chk("R3 depth3 wins", S_D3, 0, 0, 0);
    break_to_run("R3 exit");
    halt = 1; mwait = 1; mdepth = 2'd1; plvl2 = 1; tick();
    chk("R3 depth2 wins", S_D2, 0, 0, 0);
    break_to_run("R3 exit");
    halt = 1; mwait = 1; mdepth = 2'd0; tick();
    chk("R3 mwait1 beats halt", S_MW, 0, 0, 0);
    break_to_run("R3 exit");
  endtask

  task automatic t_halt_wake();
    halt = 1; tick();
    mon = 1; tick(); chk("R4 monitor alone keeps halt", S_HALT, 0, 0, 0);
    tick();
    for (int i = 0; i < NUM_BRK; i++) begin
      if (state != S_HALT) begin halt = 1; tick(); end
      brk[i] = 1; tick();
      chk($sformatf("R4 break bit %0d", i), S_RUN, 1, 1, 0);
      tick();
    end
  endtask

  task automatic t_deep_gating();
    plvl2 = 1; tick();
    clkstop = 1; brk[3] = 1; mon = 1; tick();
    chk("R7 clock-stop ignored in depth2 / R5 break gated", S_D2, 0, 0, 0);
    tick(); clkstop = 0; tick();
    chk("R7 release ignored in depth2", S_D2, 0, 0, 0);
    break_to_run("R5 depth2 wakes after gate clears");
    plvl3 = 1; tick();
    clkstop = 1; tick(); chk("R7 clock-stop ignored in depth3", S_D3, 0, 0, 0);
    clkstop = 0; tick(); chk("R7 release ignored in depth3", S_D3, 0, 0, 0);
    break_to_run("R5 depth3 exit");
  endtask

  task automatic t_stop_grant();
    halt = 1; tick();
    clkstop = 1; tick(); chk("R6 halt to stop-grant", S_SG, 0, 0, 0);
    brk[5] = 1; mon = 1; tick(); chk("R7 break ignored in stop-grant", S_SG, 0, 0, 0);
    snoop = 1; tick(); chk("R7 snoop ignored in stop-grant", S_SG, 0, 0, 0);
    clkstop = 0; tick(); chk("R6 return to halt", S_HALT, 0, 0, 0);
    break_to_run("R6 exit");
    mwait = 1; mdepth = 2'd1; tick();
    clkstop = 1; tick(); chk("R6 mwait to stop-grant", S_SG, 0, 0, 0);
    clkstop = 0; tick(); chk("R6 return to mwait", S_MW, 0, 0, 0);
    break_to_run("R6 exit");
  endtask

  task automatic t_snoop();
    halt = 1; tick();
    snoop = 1; tick(); chk("R8 snoop sub-state", S_SN, 0, 0, 1);
    tick(); chk("R8 back to halt", S_HALT, 0, 0, 0);
    break_to_run("R8 exit");
    plvl3 = 1; tick();
    snoop = 1; tick(); chk("R8 snoop ignored in depth3", S_D3, 0, 0, 0);
    break_to_run("R8 exit");
  endtask

  task automatic t_core_reset();
    halt = 1; tick();
    clkstop = 1; tick();
    core_rst = 1; tick(); chk("R1 core reset from stop-grant", S_RUN, 1, 0, 0);
    clkstop = 0; tick();
    halt = 1; tick(); snoop = 1; tick();
    core_rst = 1; tick(); chk("R1 core reset from snoop", S_RUN, 1, 0, 0);
    plvl3 = 1; tick();
    core_rst = 1; tick(); chk("R1 core reset from depth3", S_RUN, 1, 0, 0);
    tick(); chk("R10 no late wake", S_RUN, 1, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual hung expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_entries();
    t_priority();
    t_halt_wake();
    t_deep_gating();
    t_stop_grant();
    t_snoop();
    t_core_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule